// File: doc/BRIEF.md
# Parallel delay-commutator data shuffler

This block sits between two stages of a parallel feedforward FFT pipeline and reorders the stream so that the next stage's butterflies receive the sample pairs they need. It takes `LANES` words per clock, where `LANES` is a power of two. The lanes are handled in pairs: the even lane 2i and the odd lane 2i+1 form pair i. Each pair is a delay-commutator. The odd input is delayed by `DEPTH` words. Two opposed 2-to-1 selectors then either pass the pair straight or cross it. The upper result is delayed by another `DEPTH` words before it leaves on the even output lane. The selectors change setting after every `DEPTH` accepted samples, so blocks of `DEPTH` samples are exchanged between the two lanes of each pair.

All pairs share a single address counter. The delays are therefore packed into two memories, each `DEPTH` rows deep and `WIDTH*LANES/2` bits wide: one holds the input-side delays and one holds the output-side delays. Each pair owns a fixed slice of every row. The counter and the phase logic advance only on cycles where `in_valid` is high, so idle cycles freeze the whole block.

When the `BYPASS` parameter is set, the block becomes a stage with fixed wiring only. It has no memory and no selectors, and each output lane carries a fixed input lane. Lane j occupies bits `[j*WIDTH +: WIDTH]` of both data buses. `DEPTH` must be a power of two of at least 2.

Top module: `shuf_commutator`

## Requirements
- R1: While `rst` is high at a clock edge, the block clears its state: after that edge `out_valid` is 0 and every bit of `out_data` is 0.
- R2: Count accepted samples k from 0 after reset. In shuffle mode, the odd output lane 2i+1 for sample k equals even input lane 2i of sample k when the phase of k is 1, and odd input lane 2i+1 of sample k-DEPTH when the phase is 0.
- R3: In shuffle mode, the even output lane 2i for sample k equals odd input lane 2i+1 of sample k-2*DEPTH when the phase of sample k-DEPTH is 1, and even input lane 2i of sample k-DEPTH when that phase is 0.
- R4: The phase of sample k is floor(k/DEPTH) mod 2. The first `DEPTH` samples after reset pass straight (phase 0), and the shared address steps by one modulo `DEPTH` for each accepted sample.
- R5: The result for sample k appears one clock after the cycle in which the sample is accepted. `out_valid` is 1 in that cycle only if k >= DEPTH.
- R6: A cycle with `in_valid` low has no effect. In the next cycle `out_valid` is 0 and `out_data` is unchanged, and the sample count and phase do not advance.
- R7: A synchronous reset in the middle of a stream restarts the count at k = 0. The `DEPTH` samples that follow are not flagged valid, even though the memories keep their old contents.
- R8: With `BYPASS` set, output lane j one clock after an accepted cycle equals input lane bitrev(j), where bitrev reverses the log2(LANES) index bits. `out_valid` follows `in_valid` with one clock of delay, and idle cycles hold `out_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input lanes carry a sample this cycle |
| in_data | input | LANES*WIDTH | Input lanes, lane j at bits j*WIDTH +: WIDTH |
| out_valid | output | 1 | Output lanes carry a finished sample |
| out_data | output | LANES*WIDTH | Output lanes, lane j at bits j*WIDTH +: WIDTH |

## Verification
The assertions check the properties that hold on every cycle. They cover the address step and the phase flip at each wrap, the quiet hold on idle cycles, the suppression of `out_valid` until the first `DEPTH` samples have been taken, the crossed-phase path from even input to odd output, and the fixed lane permutation in bypass mode. The paths through the two delay memories need the history of samples `DEPTH` and `2*DEPTH` back. Only the bench scenarios can show that behaviour: long straight runs, runs broken by idle cycles, a reset in the middle of a stream, and a bypass instance, all checked against a model of the sample history that the bench keeps for itself.

// File: rtl/shuf_pkg.sv
package shuf_pkg;

  // Low bit of lane `lane` in a flat bus of `width`-bit lanes.
  function automatic int lane_lo(input int lane, input int width);
    return lane * width;
  endfunction

  // Reverse the low `nbits` bits of `value`.
  function automatic int bit_rev(input int value, input int nbits);
    int r;
    r = 0;
    for (int b = 0; b < nbits; b++) begin
      if (((value >> b) & 1) != 0) r = r | (1 << (nbits - 1 - b));
    end
    return r;
  endfunction

  // Index of the last row of a modulo-depth address.
  function automatic int last_row(input int depth);
    return depth - 1;
  endfunction

endpackage

// File: rtl/shuf_phase_ctl.sv
module shuf_phase_ctl #(
  parameter int DEPTH = 16,
  parameter int PTR_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             adv,
  output logic [PTR_W-1:0] ptr,
  output logic             sel,
  output logic             wrap,
  output logic             filled
);

  assign wrap = adv && (ptr == PTR_W'(shuf_pkg::last_row(DEPTH)));

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr    <= '0;
      sel    <= 1'b0;
      filled <= 1'b0;
    end else if (adv) begin
      ptr <= ptr + 1'b1;
      if (wrap) begin
        sel    <= ~sel;
        filled <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/shuf_delay_mem.sv
module shuf_delay_mem #(
  parameter int DEPTH  = 16,
  parameter int ROW_W  = 64,
  parameter int PTR_W  = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic [PTR_W-1:0] addr,
  input  logic [ROW_W-1:0] wdata,
  output logic [ROW_W-1:0] rdata
);

  logic [ROW_W-1:0] rows [DEPTH];

  // Read the old row, overwrite it at the edge: a row returns DEPTH writes later.
  assign rdata = rows[addr];

  always_ff @(posedge clk) begin
    if (wr_en) rows[addr] <= wdata;
  end

endmodule

// File: rtl/shuf_pair_swap.sv
module shuf_pair_swap #(
  parameter int WIDTH = 16
) (
  input  logic             sel,
  input  logic [WIDTH-1:0] a_now,
  input  logic [WIDTH-1:0] b_late,
  output logic [WIDTH-1:0] top,
  output logic [WIDTH-1:0] bot
);

  // Opposed selectors: straight on phase 0, crossed on phase 1.
  assign top = sel ? b_late : a_now;
  assign bot = sel ? a_now  : b_late;

endmodule

// File: rtl/shuf_commutator.sv
module shuf_commutator #(
  parameter int LANES  = 8,
  parameter int DEPTH  = 16,
  parameter int WIDTH  = 16,
  parameter bit BYPASS = 1'b0
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   in_valid,
  input  logic [LANES*WIDTH-1:0] in_data,
  output logic                   out_valid,
  output logic [LANES*WIDTH-1:0] out_data
);

  localparam int PAIRS     = LANES / 2;
  localparam int PTR_W     = $clog2(DEPTH);
  localparam int ROW_W     = WIDTH * PAIRS;
  localparam int LANE_BITS = $clog2(LANES);

  // Internal events brought out for the checker.
  logic [PTR_W-1:0]       ptr;
  logic                   sel;
  logic                   wrap;
  logic                   filled;

  logic                   out_valid_q;
  logic [LANES*WIDTH-1:0] out_data_q;

  generate
    if (BYPASS) begin : g_wire
      logic [LANES*WIDTH-1:0] perm;

      for (genvar j = 0; j < LANES; j++) begin : g_lane
        assign perm[shuf_pkg::lane_lo(j, WIDTH) +: WIDTH] =
          in_data[shuf_pkg::lane_lo(shuf_pkg::bit_rev(j, LANE_BITS), WIDTH) +: WIDTH];
      end

      assign ptr    = '0;
      assign sel    = 1'b0;
      assign wrap   = 1'b0;
      assign filled = 1'b0;

      always_ff @(posedge clk) begin
        if (rst) begin
          out_valid_q <= 1'b0;
          out_data_q  <= '0;
        end else begin
          out_valid_q <= in_valid;
          if (in_valid) out_data_q <= perm;
        end
      end
    end else begin : g_shuffle
      logic [ROW_W-1:0]       in_row;
      logic [ROW_W-1:0]       in_late;
      logic [ROW_W-1:0]       top_row;
      logic [ROW_W-1:0]       top_late;
      logic [ROW_W-1:0]       bot_row;
      logic [LANES*WIDTH-1:0] nxt_out;

      shuf_phase_ctl #(.DEPTH(DEPTH), .PTR_W(PTR_W)) u_phase (
        .clk    (clk),
        .rst    (rst),
        .adv    (in_valid),
        .ptr    (ptr),
        .sel    (sel),
        .wrap   (wrap),
        .filled (filled)
      );

      for (genvar i = 0; i < PAIRS; i++) begin : g_pair
        assign in_row[shuf_pkg::lane_lo(i, WIDTH) +: WIDTH] =
          in_data[shuf_pkg::lane_lo(2*i + 1, WIDTH) +: WIDTH];

        shuf_pair_swap #(.WIDTH(WIDTH)) u_swap (
          .sel    (sel),
          .a_now  (in_data[shuf_pkg::lane_lo(2*i, WIDTH) +: WIDTH]),
          .b_late (in_late[shuf_pkg::lane_lo(i, WIDTH) +: WIDTH]),
          .top    (top_row[shuf_pkg::lane_lo(i, WIDTH) +: WIDTH]),
          .bot    (bot_row[shuf_pkg::lane_lo(i, WIDTH) +: WIDTH])
        );

        assign nxt_out[shuf_pkg::lane_lo(2*i, WIDTH) +: WIDTH] =
          top_late[shuf_pkg::lane_lo(i, WIDTH) +: WIDTH];
        assign nxt_out[shuf_pkg::lane_lo(2*i + 1, WIDTH) +: WIDTH] =
          bot_row[shuf_pkg::lane_lo(i, WIDTH) +: WIDTH];
      end

      // Input-side delays of all pairs, one row per address.
      shuf_delay_mem #(.DEPTH(DEPTH), .ROW_W(ROW_W), .PTR_W(PTR_W)) u_in_dly (
        .clk   (clk),
        .wr_en (in_valid),
        .addr  (ptr),
        .wdata (in_row),
        .rdata (in_late)
      );

      // Output-side delays of all pairs, same address.
      shuf_delay_mem #(.DEPTH(DEPTH), .ROW_W(ROW_W), .PTR_W(PTR_W)) u_out_dly (
        .clk   (clk),
        .wr_en (in_valid),
        .addr  (ptr),
        .wdata (top_row),
        .rdata (top_late)
      );

      always_ff @(posedge clk) begin
        if (rst) begin
          out_valid_q <= 1'b0;
          out_data_q  <= '0;
        end else begin
          out_valid_q <= in_valid && filled;
          if (in_valid) out_data_q <= nxt_out;
        end
      end
    end
  endgenerate

  assign out_valid = out_valid_q;
  assign out_data  = out_data_q;

endmodule

// File: rtl/shuf_commutator_chk.sv
module shuf_commutator_chk #(
  parameter int LANES  = 8,
  parameter int DEPTH  = 16,
  parameter int WIDTH  = 16,
  parameter bit BYPASS = 1'b0,
  parameter int PTR_W  = $clog2(DEPTH)
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   in_valid,
  input logic [LANES*WIDTH-1:0] in_data,
  input logic                   out_valid,
  input logic [LANES*WIDTH-1:0] out_data,
  input logic [PTR_W-1:0]       ptr,
  input logic                   sel,
  input logic                   wrap,
  input logic                   filled
);

  localparam int LANE_BITS = $clog2(LANES);

  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (!out_valid && out_data == '0));

  p_idle_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && $stable(out_data)));

  generate
    if (BYPASS) begin : g_wire_chk
      p_wire_valid_r8: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

      for (genvar j = 0; j < LANES; j++) begin : g_lane
        p_wire_perm_r8: assert property (@(posedge clk) disable iff (rst)
          in_valid |=> out_data[j*WIDTH +: WIDTH] ==
            $past(in_data[shuf_pkg::bit_rev(j, LANE_BITS)*WIDTH +: WIDTH]));
      end
    end else begin : g_shuffle_chk
      p_ptr_step_r4: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> ptr == $past(ptr) + PTR_W'(1));

      p_ptr_hold_r6: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(ptr) && $stable(sel));

      p_sel_flip_r4: assert property (@(posedge clk) disable iff (rst)
        wrap |=> sel != $past(sel));

      p_sel_keep_r4: assert property (@(posedge clk) disable iff (rst)
        !wrap |=> $stable(sel));

      p_fill_gate_r5: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !filled) |=> !out_valid);

      p_fill_pass_r5: assert property (@(posedge clk) disable iff (rst)
        (in_valid && filled) |=> out_valid);

      for (genvar i = 0; i < LANES/2; i++) begin : g_pair
        p_cross_path_r2: assert property (@(posedge clk) disable iff (rst)
          (in_valid && filled && sel) |=>
            out_data[(2*i+1)*WIDTH +: WIDTH] == $past(in_data[(2*i)*WIDTH +: WIDTH]));
      end
    end
  endgenerate

endmodule

bind shuf_commutator shuf_commutator_chk #(
  .LANES  (LANES),
  .DEPTH  (DEPTH),
  .WIDTH  (WIDTH),
  .BYPASS (BYPASS)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_data   (in_data),
  .out_valid (out_valid),
  .out_data  (out_data),
  .ptr       (ptr),
  .sel       (sel),
  .wrap      (wrap),
  .filled    (filled)
);

// File: tb/test_shuf_commutator.sv
`timescale 1ns/1ps
module test_shuf_commutator;

  localparam int P  = 4;
  localparam int L  = 4;
  localparam int W  = 8;
  localparam int LB = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic           in_valid = 1'b0;
  logic [P*W-1:0] in_data  = '0;
  logic           out_valid;
  logic [P*W-1:0] out_data;

  logic           b_valid = 1'b0;
  logic [P*W-1:0] b_data  = '0;
  logic           b_ovalid;
  logic [P*W-1:0] b_odata;

  shuf_commutator #(.LANES(P), .DEPTH(L), .WIDTH(W), .BYPASS(1'b0)) i_shuf_commutator (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .out_valid(out_valid), .out_data(out_data));

  shuf_commutator #(.LANES(P), .DEPTH(L), .WIDTH(W), .BYPASS(1'b1)) i_shuf_commutator_byp (
    .clk(clk), .rst(rst), .in_valid(b_valid), .in_data(b_data),
    .out_valid(b_ovalid), .out_data(b_odata));

  int checks = 0;
  int errors = 0;
  int k      = 0;
  bit done   = 1'b0;
  string ctx = "";
  logic [W-1:0]   hist [0:511][0:P-1];
  logic [P*W-1:0] last_out;
  logic [P*W-1:0] last_b;

  function automatic int phase_of(input int kk);
    return (kk / L) % 2;
  endfunction

  function automatic int rev_idx(input int j);
    int r, t;
    r = 0; t = j;
    for (int b = 0; b < LB; b++) begin
      r = (r << 1) | (t & 1);
      t = t >> 1;
    end
    return r;
  endfunction

  function automatic logic [W-1:0] expect_lane(input int j, input int kk);
    if (j % 2 == 1) begin
      if (phase_of(kk) == 1) return hist[kk][j-1];
      return hist[kk-L][j];
    end
    if (phase_of(kk-L) == 1) return hist[kk-2*L][j+1];
    return hist[kk-L][j];
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, ctx, act, exp);
    end
  endtask

  // One cycle on the shuffle instance, checked against the sample history.
  task automatic step(input bit v, input int seed);
    logic [P*W-1:0] d;
    for (int j = 0; j < P; j++) d[j*W +: W] = W'(seed * 13 + j * 41 + 5);
    in_valid = v;
    in_data  = d;
    if (v) for (int j = 0; j < P; j++) hist[k][j] = d[j*W +: W];
    @(posedge clk); #1;
    if (v) begin
      chk(out_valid == (k >= L), "R5", longint'(out_valid), longint'(k >= L));
      if (k >= L) begin
        for (int j = 0; j < P; j++) begin
          if (j % 2 == 1)
            chk(out_data[j*W +: W] == expect_lane(j, k), "R2,R4",
                longint'(out_data[j*W +: W]), longint'(expect_lane(j, k)));
          else
            chk(out_data[j*W +: W] == expect_lane(j, k), "R3,R4",
                longint'(out_data[j*W +: W]), longint'(expect_lane(j, k)));
        end
      end
      k++;
    end else begin
      chk(out_valid == 1'b0, "R6", longint'(out_valid), 0);
      chk(out_data == last_out, "R6", longint'(out_data), longint'(last_out));
    end
    last_out = out_data;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    in_valid = 1'b0;
    b_valid = 1'b0;
    @(posedge clk); #1;
    @(posedge clk); #1;
    rst = 1'b0;
    k = 0;
    last_out = out_data;
    last_b = b_odata;
  endtask

  task automatic t_reset_state();
    ctx = "reset state";
    do_reset();
    chk(out_valid == 1'b0, "R1", longint'(out_valid), 0);
    chk(out_data == '0, "R1", longint'(out_data), 0);
    chk(b_ovalid == 1'b0, "R1", longint'(b_ovalid), 0);
    chk(b_odata == '0, "R1", longint'(b_odata), 0);
  endtask

  task automatic t_long_stream();
    ctx = "straight run";
    for (int n = 0; n < 6*L; n++) step(1'b1, n + 3);
  endtask

  task automatic t_gapped();
    ctx = "gapped run";
    for (int n = 0; n < 6*L; n++) step((n % 3) != 2, n * 7 + 100);
  endtask

  task automatic t_midreset();
    ctx = "R7 restart";
    for (int n = 0; n < 5; n++) step(1'b1, n + 200);
    do_reset();
    chk(out_valid == 1'b0, "R7", longint'(out_valid), 0);
    for (int n = 0; n < 3*L; n++) step(1'b1, n + 300);
    chk(k == 3*L, "R7", longint'(k), longint'(3*L));
  endtask

  task automatic bstep(input bit v, input int seed);
    logic [P*W-1:0] d;
    for (int j = 0; j < P; j++) d[j*W +: W] = W'(seed * 29 + j * 17 + 1);
    b_valid = v;
    b_data  = d;
    @(posedge clk); #1;
    if (v) begin
      chk(b_ovalid == 1'b1, "R8", longint'(b_ovalid), 1);
      for (int j = 0; j < P; j++)
        chk(b_odata[j*W +: W] == d[rev_idx(j)*W +: W], "R8",
            longint'(b_odata[j*W +: W]), longint'(d[rev_idx(j)*W +: W]));
    end else begin
      chk(b_ovalid == 1'b0, "R8", longint'(b_ovalid), 0);
      chk(b_odata == last_b, "R8", longint'(b_odata), longint'(last_b));
    end
    last_b = b_odata;
  endtask

  task automatic t_bypass();
    ctx = "fixed wiring";
    for (int n = 0; n < 10; n++) bstep((n % 4) != 3, n + 7);
    b_valid = 1'b0;
  endtask

  initial begin
    t_reset_state();
    t_long_stream();
    do_reset();
    t_gapped();
    t_midreset();
    t_bypass();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(100000 * 4);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule